// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor-side byte port and a lower memory that moves one whole block per transaction. Each address is divided into three fields. The low bits give the byte position inside a block. The middle bits choose one of the lines. The high bits form the tag kept with the line. Every line holds a valid flag, a dirty flag, a tag and one data block. A read hit returns the addressed byte one cycle after the request is accepted. On a miss the processor side waits while the controller handles the memory. If the victim line is dirty, it is first written out to its own block address. The controller then fetches the new block.

Two mode inputs are sampled with each request. The first selects what a write miss does: either the block is loaded and then updated, or only memory is updated and the cache is left unchanged. The second selects whether a write also goes to memory at once, or only marks the line dirty. A byte write changes a whole block through read-modify-write: the byte is merged into the block that is either already cached or just fetched.

The processor holds `cpu_req` and its fields stable until `cpu_done` pulses. The memory side holds `mem_req` and its fields stable until `mem_ack` pulses. Read data is valid in the same cycle as the acknowledge.

Top module: `wbc_top`

## Requirements
- R1: The address is split, from the least significant bit upward, into OFF_W byte-offset bits, IDX_W line-index bits and the remaining tag bits. Every memory transaction carries the block address, which is the CPU address shifted right by OFF_W. Byte k of a block sits at data bits [8k+7:8k].
- R2: After reset no line is valid, `cpu_done` and `mem_req` are low, and the first access to any address misses.
- R3: A read hits only when the indexed line is valid and its tag equals the address tag. A hit returns the byte at the address offset with `cpu_done` one cycle after acceptance, and it makes no memory transaction.
- R4: With 4 lines of 8 bytes and 7-bit addresses, reads of 78, 79, 80, 77, 109, 27, 81 from reset give miss, hit, miss, hit, miss, miss, hit.
- R5: A read miss fetches the whole block, installs it as a valid clean line and returns the addressed byte of that block.
- R6: A miss that replaces a valid dirty line first writes the old block to its own block address, then fetches. A clean victim is overwritten with no write to memory.
- R7: A write hit in write-back mode changes only the addressed byte of the line, marks the line dirty, completes one cycle after acceptance and makes no memory transaction.
- R8: In write-through mode every write that lands in the cache also writes the whole merged block to memory, and the line is left clean.
- R9: A write miss with allocation on fetches the block (after any dirty write-back), merges the byte, and then follows R7 or R8.
- R10: A write miss with allocation off reads the block from memory, merges the byte and writes the block back. No line changes, so a later read of that address still misses.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable while a request waits for `mem_ack`. Each acknowledge ends exactly one block transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| wr_alloc | input | 1 | 1 = load block on write miss, 0 = write memory only |
| wr_through | input | 1 | 1 = writes also go to memory, 0 = writes mark line dirty |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_done` |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | 8*BLOCK_BYTES | Block to write |
| mem_rdata | input | 8*BLOCK_BYTES | Fetched block, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The hardest case to reach is a miss whose victim is dirty and which is itself a write. This needs a write-back write to one line, followed by a write with a different tag to the same index. That write must then take the write-back, fetch, merge and, in write-through mode, a final block write, all in order. The directed part builds this case on purpose and then checks the memory image byte by byte. After that, a long run of accesses with random addresses over a 128-byte space and random mode bits meets many conflicts in just four lines. A behavioural model in the bench predicts the exact list of memory transactions, the returned byte and the full memory image for every access.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WBACK = 3'd1,
        ST_FILL  = 3'd2,
        ST_ARD   = 3'd3,
        ST_MWR   = 3'd4
    } wbc_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 2,
    parameter int BLK_W = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_data
);
    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        logic [BLK_W-1:0] data;
    } line_t;

    line_t lines_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_t ln_d, ln_q;

        always_comb begin
            ln_d = ln_q;
            if (wr_en && wr_idx == IDX_W'(i)) begin
                ln_d.valid = wr_valid;
                ln_d.dirty = wr_dirty;
                ln_d.tag   = wr_tag;
                ln_d.data  = wr_data;
            end
        end

        // R2: every line starts invalid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ln_q <= '0;
            else        ln_q <= ln_d;
        end

        assign lines_q[i] = ln_q;
    end

    assign rd_valid = lines_q[rd_idx].valid;
    assign rd_dirty = lines_q[rd_idx].dirty;
    assign rd_tag   = lines_q[rd_idx].tag;
    assign rd_data  = lines_q[rd_idx].data;
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int LINES       = 4,
    parameter int BLOCK_BYTES = 8,
    localparam int OFF_W   = $clog2(BLOCK_BYTES),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int BLK_W   = 8 * BLOCK_BYTES,
    localparam int BADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               wr_alloc,
    input  logic               wr_through,
    output logic               cpu_done,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]   mem_wdata,
    input  logic [BLK_W-1:0]   mem_rdata,
    input  logic               mem_ack,
    output logic [IDX_W-1:0]   st_rd_idx,
    input  logic               st_valid,
    input  logic               st_dirty,
    input  logic [TAG_W-1:0]   st_tag,
    input  logic [BLK_W-1:0]   st_data,
    output logic               st_wr_en,
    output logic [IDX_W-1:0]   st_wr_idx,
    output logic               st_wr_valid,
    output logic               st_wr_dirty,
    output logic [TAG_W-1:0]   st_wr_tag,
    output logic [BLK_W-1:0]   st_wr_data
);
    typedef struct packed {
        wbc_state_e         state;
        logic               done;
        logic [7:0]         rdata;
        logic               mreq;
        logic               mwe;
        logic [BADDR_W-1:0] maddr;
        logic [BLK_W-1:0]   mwdata;
        logic               around;
    } regs_t;

    regs_t r_d, r_q;

    // R1: field split of the byte address
    logic [OFF_W-1:0] addr_off;
    logic [IDX_W-1:0] addr_idx;
    logic [TAG_W-1:0] addr_tag;
    assign addr_off = cpu_addr[OFF_W-1:0];
    assign addr_idx = cpu_addr[OFF_W +: IDX_W];
    assign addr_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] o,
                                                  input logic [7:0]       b);
        logic [BLK_W-1:0] res;
        res = blk;
        res[{o, 3'b000} +: 8] = b;
        return res;
    endfunction

    logic             line_hit;
    logic [BLK_W-1:0] hit_merged;
    assign line_hit   = st_valid && (st_tag == addr_tag);
    assign hit_merged = put_byte(st_data, addr_off, cpu_wdata);
    assign st_rd_idx  = addr_idx;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        st_wr_en    = 1'b0;
        st_wr_idx   = addr_idx;
        st_wr_valid = st_valid;
        st_wr_dirty = st_dirty;
        st_wr_tag   = st_tag;
        st_wr_data  = st_data;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (line_hit) begin
                        if (!cpu_we) begin
                            // R3: one-cycle read hit
                            r_d.done  = 1'b1;
                            r_d.rdata = st_data[{addr_off, 3'b000} +: 8];
                        end else begin
                            // R7 / R8: merge into the cached block
                            st_wr_en    = 1'b1;
                            st_wr_valid = 1'b1;
                            st_wr_tag   = addr_tag;
                            st_wr_data  = hit_merged;
                            st_wr_dirty = !wr_through;
                            if (wr_through) begin
                                r_d.mreq   = 1'b1;
                                r_d.mwe    = 1'b1;
                                r_d.maddr  = {addr_tag, addr_idx};
                                r_d.mwdata = hit_merged;
                                r_d.state  = ST_MWR;
                            end else begin
                                r_d.done = 1'b1;
                            end
                        end
                    end else if (cpu_we && !wr_alloc) begin
                        // R10: write around the cache
                        r_d.around = 1'b1;
                        r_d.mreq   = 1'b1;
                        r_d.mwe    = 1'b0;
                        r_d.maddr  = {addr_tag, addr_idx};
                        r_d.state  = ST_ARD;
                    end else if (st_valid && st_dirty) begin
                        // R6: dirty victim goes out first
                        r_d.mreq   = 1'b1;
                        r_d.mwe    = 1'b1;
                        r_d.maddr  = {st_tag, addr_idx};
                        r_d.mwdata = st_data;
                        r_d.state  = ST_WBACK;
                    end else begin
                        r_d.mreq  = 1'b1;
                        r_d.mwe   = 1'b0;
                        r_d.maddr = {addr_tag, addr_idx};
                        r_d.state = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    st_wr_en    = 1'b1;
                    st_wr_dirty = 1'b0;
                    r_d.mwe     = 1'b0;
                    r_d.maddr   = {addr_tag, addr_idx};
                    r_d.state   = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    // R5: install clean, then re-run the lookup
                    st_wr_en    = 1'b1;
                    st_wr_valid = 1'b1;
                    st_wr_dirty = 1'b0;
                    st_wr_tag   = addr_tag;
                    st_wr_data  = mem_rdata;
                    r_d.mreq    = 1'b0;
                    r_d.state   = ST_IDLE;
                end
            end
            ST_ARD: begin
                if (mem_ack) begin
                    r_d.mwe    = 1'b1;
                    r_d.mwdata = put_byte(mem_rdata, addr_off, cpu_wdata);
                    r_d.state  = ST_MWR;
                end
            end
            ST_MWR: begin
                if (mem_ack) begin
                    r_d.mreq   = 1'b0;
                    r_d.mwe    = 1'b0;
                    r_d.around = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_done  = r_q.done;
    assign cpu_rdata = r_q.rdata;
    assign mem_req   = r_q.mreq;
    assign mem_we    = r_q.mwe;
    assign mem_addr  = r_q.maddr;
    assign mem_wdata = r_q.mwdata;

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_fill_after_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FILL) |-> !(st_valid && st_dirty));

    assert_fill_leaves_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FILL && mem_ack) |=> (st_valid && !st_dirty && st_tag == $past(addr_tag)));

    assert_around_keeps_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.around |-> !st_wr_en);
endmodule

// File: rtl/wbc_top.sv
module wbc_top #(
    parameter int ADDR_W      = 7,
    parameter int LINES       = 4,
    parameter int BLOCK_BYTES = 8,
    localparam int OFF_W   = $clog2(BLOCK_BYTES),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int BLK_W   = 8 * BLOCK_BYTES,
    localparam int BADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               wr_alloc,
    input  logic               wr_through,
    output logic               cpu_done,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]   mem_wdata,
    input  logic [BLK_W-1:0]   mem_rdata,
    input  logic               mem_ack
);
    logic [IDX_W-1:0] st_rd_idx, st_wr_idx;
    logic             st_valid, st_dirty, st_wr_en, st_wr_valid, st_wr_dirty;
    logic [TAG_W-1:0] st_tag, st_wr_tag;
    logic [BLK_W-1:0] st_data, st_wr_data;

    wbc_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .wr_alloc(wr_alloc), .wr_through(wr_through),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .st_rd_idx(st_rd_idx), .st_valid(st_valid), .st_dirty(st_dirty),
        .st_tag(st_tag), .st_data(st_data),
        .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_valid(st_wr_valid),
        .st_wr_dirty(st_wr_dirty), .st_wr_tag(st_wr_tag), .st_wr_data(st_wr_data)
    );

    wbc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(st_rd_idx), .rd_valid(st_valid), .rd_dirty(st_dirty),
        .rd_tag(st_tag), .rd_data(st_data),
        .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_valid(st_wr_valid),
        .wr_dirty(st_wr_dirty), .wr_tag(st_wr_tag), .wr_data(st_wr_data)
    );
endmodule

// File: tb/wbc_top_test.sv
`timescale 1ns/1ps
module wbc_top_test;
    localparam int AW = 7;
    localparam int NL = 4;
    localparam int BB = 8;
    localparam int MSZ = 1 << AW;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, wr_alloc = 1'b1, wr_through = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic cpu_done;
    logic [7:0] cpu_rdata;
    logic mem_req, mem_we, mem_ack;
    logic [AW-4:0] mem_addr;
    logic [8*BB-1:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int pmem [MSZ];
    int ref_mem [MSZ];
    int rv [NL], rdy [NL], rt [NL];
    int rb [NL][BB];
    int exp_q [$];
    int act_q [$];

    wbc_top #(.ADDR_W(AW), .LINES(NL), .BLOCK_BYTES(BB)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .wr_alloc(wr_alloc),
        .wr_through(wr_through), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    initial forever #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural lower memory: fixed latency, one block per acknowledge
    initial begin
        int cnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            if (!rst_n || mem_ack) begin
                mem_ack <= 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt == LAT - 1) begin
                    cnt = 0;
                    if (mem_we) begin
                        for (int k = 0; k < BB; k++) pmem[int'(mem_addr)*BB + k] = int'(mem_wdata[8*k +: 8]);
                        act_q.push_back(256 | int'(mem_addr));
                    end else begin
                        for (int k = 0; k < BB; k++) mem_rdata[8*k +: 8] <= 8'(pmem[int'(mem_addr)*BB + k]);
                        act_q.push_back(int'(mem_addr));
                    end
                    mem_ack <= 1'b1;
                end else cnt++;
            end
        end
    end

    // R11: per-clock check of the memory request hold rule
    initial begin
        logic p_req = 0, p_ack = 0, p_we = 0;
        logic [AW-4:0] p_addr = '0;
        logic [8*BB-1:0] p_wd = '0;
        forever begin
            @(negedge clk);
            if (rst_n && p_req && !p_ack)
                chk(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd,
                    "R11 hold", int'(mem_addr), int'(p_addr));
            p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic predict(input bit we, input int a, input int wd, input bit alloc,
                           input bit thru, output int exp_rd, output string nm);
        int off, idx, tg, ba, vb;
        bit hit;
        off = a % BB; idx = (a / BB) % NL; tg = a / (BB * NL); ba = a / BB;
        hit = rv[idx] != 0 && rt[idx] == tg;
        exp_rd = 0;
        exp_q.delete();
        if (we && !hit && !alloc) begin
            exp_q.push_back(ba);
            exp_q.push_back(256 | ba);
            ref_mem[a] = wd;
            nm = "R10";
            return;
        end
        if (!hit) begin
            if (rv[idx] != 0 && rdy[idx] != 0) begin
                vb = rt[idx] * NL + idx;
                exp_q.push_back(256 | vb);
                for (int k = 0; k < BB; k++) ref_mem[vb*BB + k] = rb[idx][k];
                nm = "R6";
            end else nm = we ? "R9" : "R5";
            exp_q.push_back(ba);
            for (int k = 0; k < BB; k++) rb[idx][k] = ref_mem[ba*BB + k];
            rv[idx] = 1; rdy[idx] = 0; rt[idx] = tg;
        end else nm = we ? (thru ? "R8" : "R7") : "R3";
        if (!we) exp_rd = rb[idx][off];
        else begin
            rb[idx][off] = wd;
            if (thru) begin
                rdy[idx] = 0;
                exp_q.push_back(256 | ba);
                for (int k = 0; k < BB; k++) ref_mem[ba*BB + k] = rb[idx][k];
            end else rdy[idx] = 1;
        end
    endtask

    task automatic step(input bit we, input int a, input int wd, input bit alloc,
                        input bit thru, output bit obs_hit);
        int exp_rd, lat, rd, mism;
        string nm;
        predict(we, a, wd, alloc, thru, exp_rd, nm);
        act_q.delete();
        @(negedge clk);
        cpu_we = we; cpu_addr = AW'(a); cpu_wdata = 8'(wd);
        wr_alloc = alloc; wr_through = thru; cpu_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_done && lat < 400);
        rd = int'(cpu_rdata);
        cpu_req = 1'b0;
        obs_hit = (act_q.size() == 0);
        if (!we) chk(rd == exp_rd, {nm, " read byte"}, rd, exp_rd);
        chk(act_q.size() == exp_q.size(), {nm, " transaction count"}, act_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
            chk(act_q[i] == exp_q[i], {nm, " R1 transaction we|block"}, act_q[i], exp_q[i]);
        if (nm == "R3" || nm == "R7") chk(lat == 1, {nm, " hit latency"}, lat, 1);
        mism = 0;
        for (int i = 0; i < MSZ; i++) if (pmem[i] != ref_mem[i]) mism++;
        chk(mism == 0, {nm, " memory image"}, mism, 0);
    endtask

    initial begin
        int seq [7] = '{78, 79, 80, 77, 109, 27, 81};
        bit exp_hit [7] = '{0, 1, 0, 1, 0, 0, 1};
        bit h;
        for (int i = 0; i < MSZ; i++) begin pmem[i] = (i * 37 + 11) % 256; ref_mem[i] = pmem[i]; end
        for (int i = 0; i < NL; i++) begin rv[i] = 0; rdy[i] = 0; rt[i] = 0; end
        repeat (3) @(negedge clk);
        chk(cpu_done == 0, "R2 reset done", int'(cpu_done), 0);
        chk(mem_req == 0, "R2 reset mem_req", int'(mem_req), 0);
        rst_n = 1'b1;

        // R4 / R2: the reference read sequence from reset
        for (int i = 0; i < 7; i++) begin
            step(0, seq[i], 0, 1, 0, h);
            chk(h == exp_hit[i], "R4 hit pattern", int'(h), int'(exp_hit[i]));
            if (i == 0) chk(h == 0, "R2 first access misses", int'(h), 0);
        end
        // R7: write-back hit, then neighbour byte unchanged
        step(1, 81, 8'hA5, 1, 0, h);
        chk(h == 1, "R7 no memory traffic", int'(h), 1);
        step(0, 81, 0, 1, 0, h);
        step(0, 80, 0, 1, 0, h);
        // R6: same index, other tag, dirty victim
        step(0, 16, 0, 1, 0, h);
        // R6: clean victim at index 3
        step(0, 91, 0, 1, 0, h);
        // R9: write miss with allocation, write-back mode
        step(1, 40, 8'h3C, 1, 0, h);
        // R8: write-through hit on the dirty line, then evict it cleanly
        step(1, 41, 8'h5A, 1, 1, h);
        step(0, 105, 0, 1, 0, h);
        // R10: write around, cache untouched
        step(1, 100, 8'h77, 0, 0, h);
        step(0, 16, 0, 1, 0, h);
        chk(h == 1, "R10 other line kept", int'(h), 1);
        step(0, 100, 0, 1, 0, h);
        chk(h == 0, "R10 no allocation", int'(h), 0);
        // R9 + R6 + R8: dirty victim under a write-through allocating write
        step(1, 20, 8'h11, 1, 0, h);
        step(1, 53, 8'h99, 1, 1, h);
        step(0, 20, 0, 1, 0, h);

        // Mixed traffic against the reference model
        for (int n = 0; n < 400; n++) begin
            int a, w, we, al, th;
            a = $urandom_range(MSZ - 1);
            w = $urandom_range(255);
            we = $urandom_range(1);
            al = $urandom_range(1);
            th = $urandom_range(1);
            step(we[0], a, w, al[0], th[0], h);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule